// File: doc/BRIEF.md
# Non-speculative instruction hold buffer

This block parks instructions that may not execute speculatively, such as barriers and serializing operations, until the commit side lets one of them go. The commit side names the instruction only by its sequence number. Storage is therefore a small associative array searched by that number, not a FIFO. Each entry holds a sequence number, a thread identifier and an opaque payload that the surrounding pipeline uses to rebuild the instruction.

Three operations can occur in the same cycle. An insertion places a new entry in the lowest-numbered free slot. A release request looks up one entry by sequence number and hands it to the ready path for exactly one cycle. A squash removes every held entry of a given thread that is younger than the squash point, and reports how many it removed. Release and squash work on the entries present before the clock edge. A same-cycle insertion is always stored after them.

Top module: `nonspec_hold_buf`

## Requirements
- R1: After reset, `rel_out_valid`, `rel_miss`, `sq_done` and `ins_full` are all 0.
- R2: An insertion (`ins_valid`=1) while `ins_full`=0 stores the sequence number, thread and payload, so that a later release of that number returns them.
- R3: `ins_full` is 1 exactly when all DEPTH slots are occupied. An insertion in a cycle where `ins_full`=1 is dropped, and a later release of its sequence number misses.
- R4: A release request whose number matches a held entry makes `rel_out_valid` 1 in the following cycle, for one cycle. `rel_out_seq`, `rel_out_tid` and `rel_out_payload` carry that entry. Entries are released in the order requested, regardless of insertion order.
- R5: A released entry is freed at the same edge, so a second release of the same number misses.
- R6: A release request matching no held entry produces a one-cycle `rel_miss` pulse in the following cycle, with `rel_out_valid`=0, and changes no entry.
- R7: A squash removes held entries whose thread equals `sq_tid` and whose sequence number is strictly greater than `sq_seq` (unsigned compare). Entries with an equal or smaller number, and entries of other threads, stay.
- R8: A squash gives `sq_done`=1 in the following cycle, with `sq_count` equal to the number of entries that squash removed (0 allowed).
- R9: In a cycle with both a squash and a release, a release that targets an entry being squashed misses. An insertion in a squash cycle is kept even if it would match the squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | NSB_SEQ_W | Sequence number of inserted instruction |
| ins_tid | input | NSB_TID_W | Thread of inserted instruction |
| ins_payload | input | NSB_PAY_W | Instruction payload |
| ins_full | output | 1 | All slots occupied; insertions are dropped |
| rel_valid | input | 1 | Release request from commit side |
| rel_seq | input | NSB_SEQ_W | Sequence number to release |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | NSB_TID_W | Thread being squashed |
| sq_seq | input | NSB_SEQ_W | Squash point; younger entries are removed |
| rel_out_valid | output | 1 | Released instruction valid (one cycle) |
| rel_out_seq | output | NSB_SEQ_W | Released sequence number |
| rel_out_tid | output | NSB_TID_W | Released thread |
| rel_out_payload | output | NSB_PAY_W | Released payload |
| rel_miss | output | 1 | Release request found no entry |
| sq_done | output | 1 | Squash processed |
| sq_count | output | $clog2(DEPTH+1) | Entries removed by the squash |

## Verification
Directed patterns come first:
- Filling every slot and then inserting once more separates a correct full guard from a silent overwrite.
- Releasing entries out of insertion order separates a keyed lookup from FIFO behaviour.
- Releasing the same number twice shows whether a released slot is really freed.
- A squash over a mix of threads, with numbers below, equal to and above the squash point, checks the strict-younger rule and the removal count.
- A squash and a release hitting the same entry in one cycle, plus an insertion in a squash cycle, pin down the ordering within a cycle.

A long constrained-random run then mixes all operations at random, so that slot reuse and full/empty churn are compared against a bench model.

// File: rtl/nsb_pkg.sv
package nsb_pkg;
  parameter int NSB_SEQ_W = 16;
  parameter int NSB_TID_W = 2;
  parameter int NSB_PAY_W = 32;

  typedef struct packed {
    logic [NSB_SEQ_W-1:0] seq;
    logic [NSB_TID_W-1:0] tid;
    logic [NSB_PAY_W-1:0] payload;
  } nsb_entry_t;
endpackage

// File: rtl/nsb_pick.sv
module nsb_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/nsb_popcount.sv
module nsb_popcount #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(vec[i]);
  end
endmodule

// File: rtl/nonspec_hold_buf.sv
module nonspec_hold_buf
  import nsb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_valid,
  input  logic [NSB_SEQ_W-1:0] ins_seq,
  input  logic [NSB_TID_W-1:0] ins_tid,
  input  logic [NSB_PAY_W-1:0] ins_payload,
  output logic                 ins_full,
  input  logic                 rel_valid,
  input  logic [NSB_SEQ_W-1:0] rel_seq,
  input  logic                 sq_valid,
  input  logic [NSB_TID_W-1:0] sq_tid,
  input  logic [NSB_SEQ_W-1:0] sq_seq,
  output logic                 rel_out_valid,
  output logic [NSB_SEQ_W-1:0] rel_out_seq,
  output logic [NSB_TID_W-1:0] rel_out_tid,
  output logic [NSB_PAY_W-1:0] rel_out_payload,
  output logic                 rel_miss,
  output logic                 sq_done,
  output logic [CW-1:0]        sq_count
);

  // State
  logic [DEPTH-1:0] valid_q, valid_d;
  nsb_entry_t       ent_q [DEPTH];
  nsb_entry_t       out_ent_q;
  logic             out_valid_q, out_valid_d;
  logic             miss_q, miss_d;
  logic             sq_done_q;
  logic [CW-1:0]    sq_cnt_q;

  // Per-slot compare
  logic [DEPTH-1:0] kill_vec;
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign kill_vec[g] = sq_valid && valid_q[g] &&
                         (ent_q[g].tid == sq_tid) && (ent_q[g].seq > sq_seq);
    assign hit_vec[g]  = rel_valid && valid_q[g] && !kill_vec[g] &&
                         (ent_q[g].seq == rel_seq);
  end

  // Selection
  logic          free_any, hit_any;
  logic [IW-1:0] free_idx, hit_idx;
  logic [CW-1:0] kill_cnt;
  logic          ins_ok;

  nsb_pick #(.N(DEPTH), .IW(IW)) u_free (.req(~valid_q), .any(free_any), .idx(free_idx));
  nsb_pick #(.N(DEPTH), .IW(IW)) u_hit  (.req(hit_vec),  .any(hit_any),  .idx(hit_idx));
  nsb_popcount #(.N(DEPTH), .CW(CW)) u_cnt (.vec(kill_vec), .cnt(kill_cnt));

  assign ins_ok = ins_valid && free_any;

  // Next state
  always_comb begin
    valid_d = valid_q & ~kill_vec;
    if (hit_any) valid_d[hit_idx] = 1'b0;
    if (ins_ok)  valid_d[free_idx] = 1'b1;
    out_valid_d = rel_valid && hit_any;
    miss_d      = rel_valid && !hit_any;
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= '0;
      out_valid_q <= 1'b0;
      miss_q      <= 1'b0;
      sq_done_q   <= 1'b0;
    end else begin
      valid_q     <= valid_d;
      out_valid_q <= out_valid_d;
      miss_q      <= miss_d;
      sq_done_q   <= sq_valid;
    end
  end

  // Data registers with enables
  always_ff @(posedge clk) begin
    if (ins_ok) begin
      ent_q[free_idx].seq     <= ins_seq;
      ent_q[free_idx].tid     <= ins_tid;
      ent_q[free_idx].payload <= ins_payload;
    end
    if (out_valid_d) out_ent_q <= ent_q[hit_idx];
    if (sq_valid)    sq_cnt_q  <= kill_cnt;
  end

  assign ins_full        = &valid_q;
  assign rel_out_valid   = out_valid_q;
  assign rel_out_seq     = out_ent_q.seq;
  assign rel_out_tid     = out_ent_q.tid;
  assign rel_out_payload = out_ent_q.payload;
  assign rel_miss        = miss_q;
  assign sq_done         = sq_done_q;
  assign sq_count        = sq_cnt_q;

  // Assertions
  a_r3_full_drops_insert: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_full && !rel_valid && !sq_valid) |=> $stable(valid_q));

  a_r4_out_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    rel_out_valid |-> $past(rel_valid));

  a_r5_release_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && hit_any && !ins_ok && !sq_valid) |=>
      ($countones(valid_q) == $past($countones(valid_q)) - 1));

  a_r6_miss_excludes_out: assert property (@(posedge clk) disable iff (!rst_n)
    !(rel_out_valid && rel_miss));

  a_r8_done_follows_squash: assert property (@(posedge clk) disable iff (!rst_n)
    sq_done |-> ($past(sq_valid) && (sq_count <= CW'(DEPTH))));

  a_r8_count_matches_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && !rel_valid && !ins_ok) |=>
      ($countones(valid_q) + int'(sq_count) == $past($countones(valid_q))));

endmodule

// File: tb/sim_nonspec_hold_buf.sv
module sim_nonspec_hold_buf;
  import nsb_pkg::*;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic ins_valid, rel_valid, sq_valid;
  logic [NSB_SEQ_W-1:0] ins_seq, rel_seq, sq_seq;
  logic [NSB_TID_W-1:0] ins_tid, sq_tid;
  logic [NSB_PAY_W-1:0] ins_payload;
  logic ins_full, rel_out_valid, rel_miss, sq_done;
  logic [NSB_SEQ_W-1:0] rel_out_seq;
  logic [NSB_TID_W-1:0] rel_out_tid;
  logic [NSB_PAY_W-1:0] rel_out_payload;
  logic [CW-1:0] sq_count;

  always #2 clk = ~clk;

  nonspec_hold_buf #(.DEPTH(DEPTH)) u0 (.*);

  int n_chk = 0, n_fail = 0;

  // bench model
  bit                 m_v   [DEPTH];
  bit [NSB_SEQ_W-1:0] m_seq [DEPTH];
  bit [NSB_TID_W-1:0] m_tid [DEPTH];
  bit [NSB_PAY_W-1:0] m_pay [DEPTH];
  int unsigned next_seq = 10;

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit model_full();
    for (int i = 0; i < DEPTH; i++) if (!m_v[i]) return 1'b0;
    return 1'b1;
  endfunction

  // one cycle: inputs already driven at negedge
  task automatic step();
    bit k [DEPTH];
    int hit = -1, fr = -1, kc = 0;
    bit e_full;
    for (int i = 0; i < DEPTH; i++) begin
      k[i] = sq_valid && m_v[i] && m_tid[i] == sq_tid && m_seq[i] > sq_seq;
      if (k[i]) kc++;
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (rel_valid && m_v[i] && !k[i] && m_seq[i] == rel_seq) hit = i;
      if (!m_v[i]) fr = i;
    end
    @(posedge clk);
    #1;
    // R4 / R6
    chk("R4 out_valid", rel_out_valid, rel_valid && hit >= 0);
    chk("R6 miss", rel_miss, rel_valid && hit < 0);
    if (hit >= 0) begin
      chk("R4 seq", rel_out_seq, m_seq[hit]);
      chk("R4 tid", rel_out_tid, m_tid[hit]);
      chk("R2 payload", rel_out_payload, m_pay[hit]);
    end
    chk("R8 done", sq_done, sq_valid);
    if (sq_valid) chk("R8 count", sq_count, kc);
    // update model (R5 free on release, R7 squash, R9 insert kept)
    for (int i = 0; i < DEPTH; i++) if (k[i]) m_v[i] = 0;
    if (hit >= 0) m_v[hit] = 0;
    if (ins_valid && fr >= 0) begin
      m_v[fr] = 1; m_seq[fr] = ins_seq; m_tid[fr] = ins_tid; m_pay[fr] = ins_payload;
    end
    e_full = model_full();
    chk("R3 full", ins_full, e_full);
    @(negedge clk);
    ins_valid = 0; rel_valid = 0; sq_valid = 0;
  endtask

  task automatic do_ins(int tid, int seq);
    ins_valid = 1; ins_tid = NSB_TID_W'(tid); ins_seq = NSB_SEQ_W'(seq);
    ins_payload = $urandom;
  endtask

  task automatic do_rel(int seq);
    rel_valid = 1; rel_seq = NSB_SEQ_W'(seq);
  endtask

  task automatic do_sq(int tid, int seq);
    sq_valid = 1; sq_tid = NSB_TID_W'(tid); sq_seq = NSB_SEQ_W'(seq);
  endtask

  task automatic print_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    print_end();
    $finish;
  end

  initial begin
    void'($urandom(1234));
    ins_valid = 0; rel_valid = 0; sq_valid = 0;
    ins_seq = 0; ins_tid = 0; ins_payload = 0; rel_seq = 0; sq_seq = 0; sq_tid = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", rel_out_valid, 0);
    chk("R1 miss", rel_miss, 0);
    chk("R1 sq_done", sq_done, 0);
    chk("R1 full", ins_full, 0);

    // R3 fill, then one extra insert is dropped
    for (int i = 0; i < DEPTH; i++) begin do_ins(i % 4, 100 + i); step(); end
    chk("R3 full after fill", ins_full, 1);
    do_ins(1, 500); step();
    do_rel(500); step();
    // R4 out of order release, R5 double release misses
    do_rel(105); step();
    do_rel(101); step();
    do_rel(105); step();
    // R7/R8 squash thread 0 above 100: removes 104 (100 equal stays)
    do_sq(0, 100); step();
    do_rel(100); step();
    do_rel(104); step();
    // R9 release target squashed in same cycle; insert kept during squash
    do_sq(2, 101); do_rel(106); do_ins(2, 300); step();
    do_rel(300); step();
    // drain
    for (int i = 0; i < 8; i++) begin do_rel(100 + i); step(); end

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 55) begin
        next_seq += $urandom_range(1, 3);
        do_ins($urandom_range(0, 3), next_seq);
      end
      if ($urandom_range(0, 99) < 45) begin
        int s = $urandom_range(0, DEPTH - 1);
        if (m_v[s] && $urandom_range(0, 9) < 8) do_rel(m_seq[s]);
        else do_rel($urandom_range(0, next_seq + 4));
      end
      if ($urandom_range(0, 99) < 8)
        do_sq($urandom_range(0, 3), next_seq - $urandom_range(0, 20));
      step();
    end

    print_end();
    $finish;
  end
endmodule